// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank single-data-rate SDRAM. On each rising clock edge it samples the chip select, the row and column strobes, write enable, two bank-select bits and a 12-bit address. It turns the strobe pattern into a registered, one-cycle command indication: activate, precharge, read, write, mode-register load or no-operation.

Alongside the decode it tracks which banks are open and which row each bank last opened. It reports the column address and auto-precharge request of the most recent legal column command, and it latches the opcode of the last mode-register load. Illegal sequences raise a one-cycle error pulse: a column access to an idle bank, or an activate to a bank that is already open. A clock-enable input suspends the block one cycle after it is sampled low and keeps every output frozen while it stays low.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset every command strobe and the error flag are low, all banks are idle, all open-row fields, the column address, the auto-precharge flag, the bank field and the mode opcode are zero.
- R2: With `csN` sampled high the cycle is a no-operation: only `nopStb` pulses and no bank state, row, column or opcode changes.
- R3: `csN`=0, `rasN`=0, `casN`=1, `weN`=1 to an idle bank pulses `actStb`, opens that bank and stores `addr[11:0]` as its open row.
- R4: `csN`=0, `rasN`=0, `casN`=1, `weN`=0 with `addr[10]`=0 pulses `preStb` and closes only the selected bank; precharging an idle bank is legal.
- R5: The same precharge pattern with `addr[10]`=1 closes all four banks whatever `bankSel` holds.
- R6: `csN`=0, `rasN`=1, `casN`=0 to an open bank pulses `rdStb` when `weN`=1 and `wrStb` when `weN`=0, and sets `colAddr` to `addr[8:0]`, `autoPre` to `addr[10]` and `cmdBank` to `bankSel`.
- R7: A legal column command with `addr[10]`=1 closes its bank at the next active edge; a command decoded at that edge already sees the bank as closed.
- R8: `bankSel` value b selects bank b: bit b of `bankOpen` and bits [12*b+11:12*b] of `openRow`.
- R9: All four strobes low (`csN`,`rasN`,`casN`,`weN` = 0) pulses `mrsStb` and latches `addr` into `modeOp`.
- R10: An activate to an open bank or a column command to an idle bank pulses `errFlag` with no command strobe, and leaves bank state, rows, column address and auto-precharge flag unchanged.
- R11: If `clkEn` is sampled low at edge k, the command at edge k still executes, and from edge k+1 on inputs are ignored and all outputs hold; operation resumes at the edge after `clkEn` is first sampled high again.
- R12: With `csN`=0, the patterns `rasN`=1,`casN`=1 (either `weN`) and `rasN`=0,`casN`=0,`weN`=1 decode as no-operation; at most one of the six strobes and the error flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Clock enable; low suspends the block from the next cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankSel | input | 2 | Bank selection |
| addr | input | 12 | Row, column, opcode and auto-precharge address |
| actStb | output | 1 | Activate accepted |
| preStb | output | 1 | Precharge accepted |
| rdStb | output | 1 | Read accepted |
| wrStb | output | 1 | Write accepted |
| mrsStb | output | 1 | Mode-register load accepted |
| nopStb | output | 1 | No-operation or deselect |
| errFlag | output | 1 | Illegal command rejected |
| cmdBank | output | 2 | Bank of the last activate, precharge or column command |
| colAddr | output | 9 | Column of the last legal column command |
| autoPre | output | 1 | Auto-precharge request of the last legal column command |
| modeOp | output | 12 | Opcode of the last mode-register load |
| bankOpen | output | 4 | Open flag per bank |
| openRow | output | 48 | Last activated row per bank, 12 bits each |

## Verification
A wrong open flag in any bank shows on `bankOpen` in the cycle after the command that caused it, and one command later as a spurious or missing `errFlag` when that bank is next activated or accessed. A wrong row shows directly on `openRow`, and a lost auto-precharge is exposed when a column command at the following edge is accepted rather than rejected. A clock-enable fault shows as a strobe or state change during a frozen cycle, or as a command that executes when it should be ignored on the cycle enable returns.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  // Decoded command strobes passed from the decoder to the bank datapath.
  typedef struct packed {
    logic act;
    logic pre;
    logic preAll;
    logic rd;
    logic wr;
    logic mrs;
    logic nop;
    logic autoPre;
  } cmd_t;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  output cmd_t              cmd,
  output logic              step
);

  logic ckeQ;

  // Enable is registered: a low sample suspends the block from the next edge.
  always_ff @(posedge clk) begin
    if (!rstN) ckeQ <= 1'b1;
    else       ckeQ <= clkEn;
  end

  assign step = ckeQ;

  always_comb begin
    cmd         = '0;
    cmd.autoPre = addr[AP_BIT];
    if (csN) begin
      cmd.nop = 1'b1;
    end else begin
      unique case ({rasN, casN, weN})
        3'b011:  cmd.act = 1'b1;
        3'b010: begin
          cmd.pre    = 1'b1;
          cmd.preAll = addr[AP_BIT];
        end
        3'b101:  cmd.rd  = 1'b1;
        3'b100:  cmd.wr  = 1'b1;
        3'b000:  cmd.mrs = 1'b1;
        default: cmd.nop = 1'b1;
      endcase
    end
  end

  // R12: decoder never asserts two command kinds at once
  a_r12_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.act, cmd.pre, cmd.rd, cmd.wr, cmd.mrs, cmd.nop}));

endmodule

// File: rtl/sdcmd_bankpath.sv
module sdcmd_bankpath
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       step,
  input  cmd_t                       cmd,
  input  logic [BANK_W-1:0]          bankSel,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       actStb,
  output logic                       preStb,
  output logic                       rdStb,
  output logic                       wrStb,
  output logic                       mrsStb,
  output logic                       nopStb,
  output logic                       errFlag,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [COL_W-1:0]           colAddr,
  output logic                       autoPre,
  output logic [ADDR_W-1:0]          modeOp,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRow
);

  logic [NUM_BANKS-1:0] openQ;
  logic [NUM_BANKS-1:0] pendQ;
  logic [NUM_BANKS-1:0] pendNext;
  logic [NUM_BANKS-1:0] effOpen;
  logic                 selOpen;
  logic                 actOk, actBad, colOk, colBad;

  // A bank whose auto-precharge is due at this edge already counts as closed.
  assign effOpen = openQ & ~pendQ;
  assign selOpen = effOpen[bankSel];
  assign actOk   = cmd.act && !selOpen;
  assign actBad  = cmd.act && selOpen;
  assign colOk   = (cmd.rd || cmd.wr) && selOpen;
  assign colBad  = (cmd.rd || cmd.wr) && !selOpen;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : gBank
      logic             openR;
      logic [ROW_W-1:0] rowR;
      logic             hitMe;

      assign hitMe = (bankSel == BANK_W'(gi));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          openR <= 1'b0;
          rowR  <= '0;
        end else if (step) begin
          if (actOk && hitMe) begin
            openR <= 1'b1;
            rowR  <= addr[ROW_W-1:0];
          end else if (cmd.pre && (cmd.preAll || hitMe)) begin
            openR <= 1'b0;
          end else if (pendQ[gi]) begin
            openR <= 1'b0;
          end
        end
      end

      assign pendNext[gi]                 = colOk && cmd.autoPre && hitMe;
      assign openQ[gi]                    = openR;
      assign openRow[gi*ROW_W +: ROW_W]   = rowR;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      actStb  <= 1'b0;
      preStb  <= 1'b0;
      rdStb   <= 1'b0;
      wrStb   <= 1'b0;
      mrsStb  <= 1'b0;
      nopStb  <= 1'b0;
      errFlag <= 1'b0;
      cmdBank <= '0;
      colAddr <= '0;
      autoPre <= 1'b0;
      modeOp  <= '0;
    end else if (step) begin
      pendQ   <= pendNext;
      actStb  <= actOk;
      preStb  <= cmd.pre;
      rdStb   <= colOk && cmd.rd;
      wrStb   <= colOk && cmd.wr;
      mrsStb  <= cmd.mrs;
      nopStb  <= cmd.nop;
      errFlag <= actBad || colBad;
      if (cmd.act || cmd.pre || cmd.rd || cmd.wr) cmdBank <= bankSel;
      if (colOk) begin
        colAddr <= addr[COL_W-1:0];
        autoPre <= cmd.autoPre;
      end
      if (cmd.mrs) modeOp <= addr;
    end
  end

  assign bankOpen = openQ;

  // R12: at most one outcome reported per cycle
  a_r12_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({actStb, preStb, rdStb, wrStb, mrsStb, nopStb, errFlag}));

  // R3: an accepted activate leaves its bank open
  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rstN)
    actStb |-> openQ[cmdBank]);

  // R6: accepted reads and writes only target open banks
  a_r6_col_open: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb || wrStb) |-> openQ[cmdBank]);

  // R4: an accepted precharge leaves its bank idle
  a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rstN)
    preStb |-> !openQ[cmdBank]);

  // R7: at most one auto-precharge is pending at a time
  a_r7_single_pending: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendQ));

  // R11: a suspended edge changes no output
  a_r11_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable({actStb, preStb, rdStb, wrStb, mrsStb, nopStb, errFlag,
                       cmdBank, colAddr, autoPre, modeOp, openQ, openRow}));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clkEn,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BANK_W-1:0]          bankSel,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       actStb,
  output logic                       preStb,
  output logic                       rdStb,
  output logic                       wrStb,
  output logic                       mrsStb,
  output logic                       nopStb,
  output logic                       errFlag,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [COL_W-1:0]           colAddr,
  output logic                       autoPre,
  output logic [ADDR_W-1:0]          modeOp,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRow
);

  cmd_t cmd;
  logic step;

  sdcmd_decode #(
    .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT)
  ) uDecode (
    .clk  (clk),
    .rstN (rstN),
    .clkEn(clkEn),
    .csN  (csN),
    .rasN (rasN),
    .casN (casN),
    .weN  (weN),
    .addr (addr),
    .cmd  (cmd),
    .step (step)
  );

  sdcmd_bankpath #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W)
  ) uBanks (
    .clk     (clk),
    .rstN    (rstN),
    .step    (step),
    .cmd     (cmd),
    .bankSel (bankSel),
    .addr    (addr),
    .actStb  (actStb),
    .preStb  (preStb),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .mrsStb  (mrsStb),
    .nopStb  (nopStb),
    .errFlag (errFlag),
    .cmdBank (cmdBank),
    .colAddr (colAddr),
    .autoPre (autoPre),
    .modeOp  (modeOp),
    .bankOpen(bankOpen),
    .openRow (openRow)
  );

endmodule

// File: tb/sdram_cmd_tracker_test.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_test;

  logic        clk = 1'b0;
  logic        rstN, clkEn, csN, rasN, casN, weN;
  logic [1:0]  bankSel;
  logic [11:0] addr;
  logic        actStb, preStb, rdStb, wrStb, mrsStb, nopStb, errFlag;
  logic [1:0]  cmdBank;
  logic [8:0]  colAddr;
  logic        autoPre;
  logic [11:0] modeOp;
  logic [3:0]  bankOpen;
  logic [47:0] openRow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [3:0]  mOpen, mPend;
  logic [11:0] mRow [4];
  logic        mCke;
  logic [6:0]  eStb;          // {act,pre,rd,wr,mrs,nop,err}
  logic [1:0]  eBank;
  logic [8:0]  eCol;
  logic        eAp;
  logic [11:0] eMode;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .bankSel(bankSel), .addr(addr),
    .actStb(actStb), .preStb(preStb), .rdStb(rdStb), .wrStb(wrStb),
    .mrsStb(mrsStb), .nopStb(nopStb), .errFlag(errFlag), .cmdBank(cmdBank),
    .colAddr(colAddr), .autoPre(autoPre), .modeOp(modeOp),
    .bankOpen(bankOpen), .openRow(openRow)
  );

  task automatic chk(input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [47:0] rows;
    for (int b = 0; b < 4; b++) rows[b*12 +: 12] = mRow[b];
    chk(tag, "strobes", 48'({actStb, preStb, rdStb, wrStb, mrsStb, nopStb, errFlag}), 48'(eStb));
    chk(tag, "bankOpen", 48'(bankOpen), 48'(mOpen));
    chk(tag, "openRow", openRow, rows);
    chk(tag, "cmdBank", 48'(cmdBank), 48'(eBank));
    chk(tag, "colAddr", 48'({autoPre, colAddr}), 48'({eAp, eCol}));
    chk(tag, "modeOp", 48'(modeOp), 48'(eMode));
  endtask

  // Drive one command at a falling edge, step the reference, check after the edge.
  task automatic issue(input logic cs, input logic ras, input logic cas, input logic we,
                       input logic [1:0] ba, input logic [11:0] a, input logic cke,
                       input string tag);
    csN = cs; rasN = ras; casN = cas; weN = we; bankSel = ba; addr = a; clkEn = cke;
    if (mCke) begin
      logic [3:0] eff;
      logic [3:0] nPend;
      logic       isAct, isPre, isRd, isWr, isMrs;
      eff   = mOpen & ~mPend;
      nPend = '0;
      isAct = !cs && {ras, cas, we} == 3'b011;
      isPre = !cs && {ras, cas, we} == 3'b010;
      isRd  = !cs && {ras, cas, we} == 3'b101;
      isWr  = !cs && {ras, cas, we} == 3'b100;
      isMrs = !cs && {ras, cas, we} == 3'b000;
      mOpen = mOpen & ~mPend;
      eStb  = '0;
      if (isAct) begin
        if (eff[ba]) eStb[0] = 1'b1;
        else begin eStb[6] = 1'b1; mOpen[ba] = 1'b1; mRow[ba] = a; end
      end else if (isPre) begin
        eStb[5] = 1'b1;
        if (a[10]) mOpen = '0; else mOpen[ba] = 1'b0;
      end else if (isRd || isWr) begin
        if (!eff[ba]) eStb[0] = 1'b1;
        else begin
          if (isRd) eStb[4] = 1'b1; else eStb[3] = 1'b1;
          eCol = a[8:0]; eAp = a[10];
          if (a[10]) nPend[ba] = 1'b1;
        end
      end else if (isMrs) begin
        eStb[2] = 1'b1; eMode = a;
      end else begin
        eStb[1] = 1'b1;
      end
      if (isAct || isPre || isRd || isWr) eBank = ba;
      mPend = nPend;
    end
    mCke = cke;
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clkEn = 1'b1; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    bankSel = '0; addr = '0;
    mOpen = '0; mPend = '0; mCke = 1'b1;
    for (int b = 0; b < 4; b++) mRow[b] = '0;
    eStb = '0; eBank = '0; eCol = '0; eAp = 1'b0; eMode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");

    // R2: deselect with busy strobes
    issue(1, 0, 0, 0, 2'd3, 12'hFFF, 1, "R2");

    // R3, R8: activate each bank with a distinct row
    for (int b = 0; b < 4; b++)
      issue(0, 0, 1, 1, 2'(b), 12'(12'h0A5 + b * 12'h351), 1, "R3_R8");

    // R10: activate an open bank
    issue(0, 0, 1, 1, 2'd2, 12'h777, 1, "R10");

    // R6: reads and writes to every bank
    for (int b = 0; b < 4; b++) begin
      issue(0, 1, 0, 1, 2'(b), 12'(b * 37 + 5), 1, "R6");
      issue(0, 1, 0, 0, 2'(b), 12'(511 - b * 19), 1, "R6");
    end

    // R7: auto-precharge read, then a read at the next edge is rejected
    issue(0, 1, 0, 1, 2'd1, 12'h4C3, 1, "R7");
    issue(0, 1, 0, 1, 2'd1, 12'h012, 1, "R7");
    issue(0, 0, 1, 1, 2'd1, 12'h9E1, 1, "R7");
    // auto-precharge write, then activate at the next edge is accepted
    issue(0, 1, 0, 0, 2'd3, 12'h5FF, 1, "R7");
    issue(0, 0, 1, 1, 2'd3, 12'h3C3, 1, "R7");

    // R4: single-bank precharge, then a read to it is rejected (R10)
    issue(0, 0, 1, 0, 2'd0, 12'h000, 1, "R4");
    issue(0, 0, 1, 0, 2'd0, 12'h3FF, 1, "R4");
    issue(0, 1, 0, 1, 2'd0, 12'h055, 1, "R10");

    // R9: mode-register load
    issue(0, 0, 0, 0, 2'd1, 12'h233, 1, "R9");

    // R12: patterns that decode as no-operation
    issue(0, 1, 1, 1, 2'd2, 12'hABC, 1, "R12");
    issue(0, 1, 1, 0, 2'd2, 12'hABC, 1, "R12");
    issue(0, 0, 0, 1, 2'd2, 12'hABC, 1, "R12");

    // R11: enable low with an activate (executes), then frozen cycles
    issue(0, 0, 1, 1, 2'd0, 12'h6D2, 0, "R11");
    issue(0, 0, 1, 0, 2'd0, 12'h400, 0, "R11");
    issue(0, 0, 0, 0, 2'd2, 12'h111, 0, "R11");
    issue(0, 1, 0, 0, 2'd2, 12'h0EE, 1, "R11");
    issue(1, 1, 1, 1, 2'd0, 12'h000, 1, "R11");

    // R5: precharge all with an arbitrary bank select
    issue(0, 0, 1, 0, 2'd2, 12'h400, 1, "R5");

    // Near-exhaustive sweep over strobes, banks and address variants
    for (int pat = 0; pat < 16; pat++)
      for (int b = 0; b < 4; b++)
        for (int v = 0; v < 2; v++)
          issue(pat[3], pat[2], pat[1], pat[0], 2'(b),
                12'(pat * 211 + b * 97 + v * 12'h400), 1, "R12_sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule